// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control sequencer of a small accumulator machine. It moves one instruction at a time through register-transfer steps. Each instruction is fetched through an address register (MAR) and a buffer register (MBR) into an instruction register. An optional pointer read resolves an indirect operand. A load, store, add or jump then executes. At the end of an instruction the sequencer may enter an interrupt subcycle. That subcycle pushes the program counter through the MBR to a stack slot and then redirects the PC to a handler address.

All memory traffic goes over one synchronous single-port interface. The interface has one read strobe and one write strobe, and a ready input that can stretch any access. The program counter, the accumulator and the status word are brought out so the surrounding logic can observe the architectural state. The status word holds four arithmetic flags and the interrupt-enable bit.

Top module: `instr_seq`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `pc_o` is 0, `acc_o` is 0, `psw_o` is 0, neither memory strobe is active, and the internal stack pointer holds `SP_INIT`.
- R2: Each instruction begins with a read at the current PC. The PC is incremented by one in the cycle before that read starts, so `pc_o` already shows the next sequential address while the fetch read is pending.
- R3: An instruction word is decoded as follows. Bits [DW-1:DW-2] are the operation: 0 load, 1 store, 2 add, 3 jump. Bit [DW-3] is the indirect flag. Bits [AW-1:0] are the address field.
- R4: When the indirect flag is set, a second read at the address field fetches a pointer word. The low AW bits of that word become the operand address, or the jump target for a jump.
- R5: Load copies the word read at the operand address into the accumulator. Store writes the accumulator to the operand address. Jump loads the PC with the operand address and makes no data access.
- R6: Add sums the accumulator and the operand word into the accumulator. It sets the flags as follows: `psw_o[0]` zero, `psw_o[1]` unsigned carry out, `psw_o[2]` result sign, `psw_o[3]` two's-complement overflow. Load, store and jump leave these four bits unchanged.
- R7: `mem_rd` and `mem_wr` are never active together. An access keeps its strobe, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_rdy` is high. Only one access is outstanding at a time.
- R8: With `irq` high and `psw_o[4]` set when an instruction completes, the next access is a write of the PC (zero-extended) to address stack pointer minus one. The stack pointer keeps the decremented value, so a second entry saves one word lower.
- R9: After the save, the next fetch is at `ISR_ADDR`. Entry clears `psw_o[4]`, so a request that stays high does not cause another entry.
- R10: A high `ie_set` sets `psw_o[4]` on the next edge. While `psw_o[4]` is clear, `irq` has no effect on the access sequence. The interrupt request is only acted on between instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW | Memory address, driven from the MAR |
| mem_wdata | output | DW | Memory write data, driven from the MBR |
| mem_rdata | input | DW | Memory read data, valid with `mem_rdy` |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_rdy | input | 1 | Access completes in this cycle |
| irq | input | 1 | Interrupt request level |
| ie_set | input | 1 | Sets the interrupt-enable bit |
| pc_o | output | AW | Program counter |
| acc_o | output | DW | Accumulator |
| psw_o | output | 5 | {enable, overflow, sign, carry, zero} |

## Verification
The two functions that can fall in the same cycle are these. A jump writes the PC in its final execute cycle, and the interrupt decision is taken in that same cycle. The bench holds `irq` high while a jump-to-self loop runs, and sets the enable bit from the port just after the loop's fetch completes. The save write must carry the jump target, not the incremented fetch address. The stack slot of the second entry, one word below the first, shows that the decremented pointer was kept.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        S_FETCH_ADDR,
        S_FETCH_RD,
        S_FETCH_IR,
        S_IND_ADDR,
        S_IND_RD,
        S_EXEC_ADDR,
        S_EXEC_RD,
        S_EXEC_OP,
        S_EXEC_WR,
        S_INT_ENTER,
        S_INT_WR,
        S_INT_VEC
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_ADD   = 2'd2,
        OP_JUMP  = 2'd3
    } seq_op_e;

    localparam int PSW_W = 5;

    // bit order matters: zero at bit 0, carry 1, sign 2, overflow 3
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic cy;
        logic zr;
    } seq_flags_t;

endpackage

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] sum_o,
    output seq_flags_t    flags_o
);

    logic [DW:0] wide;

    always_comb begin
        wide          = {1'b0, a_i} + {1'b0, b_i};
        sum_o         = wide[DW-1:0];
        flags_o.zr    = (wide[DW-1:0] == '0);
        flags_o.cy    = wide[DW];
        flags_o.sgn   = wide[DW-1];
        flags_o.ovf   = (a_i[DW-1] == b_i[DW-1]) && (wide[DW-1] != a_i[DW-1]);
    end

endmodule

// File: rtl/seq_psw.sv
module seq_psw
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_we_i,
    input  seq_flags_t       flags_i,
    input  logic             ie_set_i,
    input  logic             ie_clr_i,
    output logic [PSW_W-1:0] psw_o,
    output logic             ie_o
);

    typedef struct packed {
        logic       ie;
        seq_flags_t fl;
    } psw_t;

    psw_t psw_d, psw_q;

    always_comb begin
        psw_d = psw_q;
        if (flag_we_i) begin
            psw_d.fl = flags_i;
        end
        if (ie_clr_i) begin
            psw_d.ie = 1'b0;
        end else if (ie_set_i) begin
            psw_d.ie = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q <= '0;
        end else begin
            psw_q <= psw_d;
        end
    end

    assign psw_o = psw_q;
    assign ie_o  = psw_q.ie;

    // R9
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr_i |=> !ie_o);

    // R10
    ie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_set_i && !ie_clr_i) |=> ie_o);

    // R6
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(psw_o[3:0]));

endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AW       = 8,
    parameter int unsigned ISR_ADDR = 'hC0,
    parameter int unsigned SP_INIT  = 'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_rdy_i,
    input  logic          irq_i,
    input  logic          ie_i,
    input  logic [DW-1:0] alu_sum_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [DW-1:0] alu_a_o,
    output logic [DW-1:0] alu_b_o,
    output logic          flag_we_o,
    output logic          ie_clr_o,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] acc_o
);

    localparam int IND_BIT = DW - 3;
    localparam int IRW     = AW + 3;
    localparam int PAD     = DW - AW;
    localparam logic [AW-1:0] ISR_VEC = AW'(ISR_ADDR);
    localparam logic [AW-1:0] SP_RST  = AW'(SP_INIT);

    typedef struct packed {
        seq_state_e     state;
        logic [AW-1:0]  pc;
        logic [AW-1:0]  mar;
        logic [AW-1:0]  sp;
        logic [IRW-1:0] ir;
        logic [DW-1:0]  mbr;
        logic [DW-1:0]  acc;
    } core_t;

    core_t   core_d, core_q;
    seq_op_e op;
    logic    ir_ind;
    logic    take_int;
    seq_state_e after_exec;

    assign op         = seq_op_e'(core_q.ir[IRW-1 -: 2]);
    assign ir_ind     = core_q.ir[IRW-3];
    assign take_int   = irq_i && ie_i;
    assign after_exec = take_int ? S_INT_ENTER : S_FETCH_ADDR;

    always_comb begin
        core_d    = core_q;
        mem_rd_o  = 1'b0;
        mem_wr_o  = 1'b0;
        flag_we_o = 1'b0;
        ie_clr_o  = 1'b0;
        case (core_q.state)
            S_FETCH_ADDR: begin
                core_d.mar   = core_q.pc;
                core_d.pc    = core_q.pc + AW'(1);
                core_d.state = S_FETCH_RD;
            end
            S_FETCH_RD: begin
                mem_rd_o = 1'b1;
                if (mem_rdy_i) begin
                    core_d.mbr   = mem_rdata_i;
                    core_d.state = S_FETCH_IR;
                end
            end
            S_FETCH_IR: begin
                core_d.ir    = {core_q.mbr[DW-1 -: 3], core_q.mbr[AW-1:0]};
                core_d.state = core_q.mbr[IND_BIT] ? S_IND_ADDR : S_EXEC_ADDR;
            end
            S_IND_ADDR: begin
                core_d.mar   = core_q.ir[AW-1:0];
                core_d.state = S_IND_RD;
            end
            S_IND_RD: begin
                mem_rd_o = 1'b1;
                if (mem_rdy_i) begin
                    core_d.mbr   = mem_rdata_i;
                    core_d.state = S_EXEC_ADDR;
                end
            end
            S_EXEC_ADDR: begin
                core_d.mar = ir_ind ? core_q.mbr[AW-1:0] : core_q.ir[AW-1:0];
                case (op)
                    OP_JUMP: begin
                        core_d.pc    = core_d.mar;
                        core_d.state = after_exec;
                    end
                    OP_STORE: begin
                        core_d.mbr   = core_q.acc;
                        core_d.state = S_EXEC_WR;
                    end
                    default: begin
                        core_d.state = S_EXEC_RD;
                    end
                endcase
            end
            S_EXEC_RD: begin
                mem_rd_o = 1'b1;
                if (mem_rdy_i) begin
                    core_d.mbr   = mem_rdata_i;
                    core_d.state = S_EXEC_OP;
                end
            end
            S_EXEC_OP: begin
                if (op == OP_ADD) begin
                    core_d.acc = alu_sum_i;
                    flag_we_o  = 1'b1;
                end else begin
                    core_d.acc = core_q.mbr;
                end
                core_d.state = after_exec;
            end
            S_EXEC_WR: begin
                mem_wr_o = 1'b1;
                if (mem_rdy_i) begin
                    core_d.state = after_exec;
                end
            end
            S_INT_ENTER: begin
                core_d.mbr   = {{PAD{1'b0}}, core_q.pc};
                core_d.sp    = core_q.sp - AW'(1);
                core_d.mar   = core_q.sp - AW'(1);
                ie_clr_o     = 1'b1;
                core_d.state = S_INT_WR;
            end
            S_INT_WR: begin
                mem_wr_o = 1'b1;
                if (mem_rdy_i) begin
                    core_d.state = S_INT_VEC;
                end
            end
            S_INT_VEC: begin
                core_d.pc    = ISR_VEC;
                core_d.state = S_FETCH_ADDR;
            end
            default: begin
                core_d.state = S_FETCH_ADDR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q       <= '0;
            core_q.state <= S_FETCH_ADDR;
            core_q.sp    <= SP_RST;
        end else begin
            core_q <= core_d;
        end
    end

    assign mem_addr_o  = core_q.mar;
    assign mem_wdata_o = core_q.mbr;
    assign alu_a_o     = core_q.acc;
    assign alu_b_o     = core_q.mbr;
    assign pc_o        = core_q.pc;
    assign acc_o       = core_q.acc;

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_rdy_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_rdy_i) |=> (mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == S_FETCH_ADDR) |=> (pc_o == $past(pc_o) + AW'(1)));

    // R10
    int_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == S_INT_ENTER) |-> (ie_i &&
            ($past(core_q.state) == S_EXEC_ADDR || $past(core_q.state) == S_EXEC_OP ||
             $past(core_q.state) == S_EXEC_WR)));

    // R8
    sp_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == S_INT_WR) |-> (mem_addr_o == core_q.sp));

    // R9
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == S_INT_VEC) |=> (pc_o == ISR_VEC));

endmodule

// File: rtl/instr_seq.sv
module instr_seq
    import seq_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AW       = 8,
    parameter int unsigned ISR_ADDR = 'hC0,
    parameter int unsigned SP_INIT  = 'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_rd,
    output logic             mem_wr,
    input  logic             mem_rdy,
    input  logic             irq,
    input  logic             ie_set,
    output logic [AW-1:0]    pc_o,
    output logic [DW-1:0]    acc_o,
    output logic [PSW_W-1:0] psw_o
);

    logic [DW-1:0] alu_a, alu_b, alu_sum;
    seq_flags_t    alu_flags;
    logic          flag_we, ie_clr, ie_q;

    seq_core #(
        .DW       (DW),
        .AW       (AW),
        .ISR_ADDR (ISR_ADDR),
        .SP_INIT  (SP_INIT)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_rdata_i (mem_rdata),
        .mem_rdy_i   (mem_rdy),
        .irq_i       (irq),
        .ie_i        (ie_q),
        .alu_sum_i   (alu_sum),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .alu_a_o     (alu_a),
        .alu_b_o     (alu_b),
        .flag_we_o   (flag_we),
        .ie_clr_o    (ie_clr),
        .pc_o        (pc_o),
        .acc_o       (acc_o)
    );

    seq_alu #(.DW(DW)) u_alu (
        .a_i     (alu_a),
        .b_i     (alu_b),
        .sum_o   (alu_sum),
        .flags_o (alu_flags)
    );

    seq_psw u_psw (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_we_i (flag_we),
        .flags_i   (alu_flags),
        .ie_set_i  (ie_set),
        .ie_clr_i  (ie_clr),
        .psw_o     (psw_o),
        .ie_o      (ie_q)
    );

endmodule

// File: tb/sim_instr_seq.sv
`timescale 1ns/1ps
module sim_instr_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rd, mem_wr, mem_rdy;
    logic        irq, ie_set;
    logic [7:0]  pc_o;
    logic [15:0] acc_o;
    logic [4:0]  psw_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    instr_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_rdy   (mem_rdy),
        .irq       (irq),
        .ie_set    (ie_set),
        .pc_o      (pc_o),
        .acc_o     (acc_o),
        .psw_o     (psw_o)
    );

    // program: op[15:14] 0 load 1 store 2 add 3 jump, [13] indirect, [7:0] address
    function automatic logic [15:0] rom_init(int a);
        case (a)
            'h00: return 16'h0040;
            'h01: return 16'h8041;
            'h02: return 16'h4050;
            'h03: return 16'hA042;
            'h04: return 16'h2044;
            'h05: return 16'hC008;
            'h08: return 16'h6046;
            'h09: return 16'hE047;
            'h0A: return 16'hC00A;
            'h40: return 16'h7FFF;
            'h41: return 16'h0001;
            'h42: return 16'h0043;
            'h43: return 16'h8000;
            'h44: return 16'h0045;
            'h45: return 16'h1234;
            'h46: return 16'h0051;
            'h47: return 16'h000A;
            'hC0: return 16'h4061;
            'hC1: return 16'hC0C1;
            default: return 16'h0000;
        endcase
    endfunction

    logic [15:0] mem [0:255];
    int          wcnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= rom_init(i);
            mem_rdy   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
        end else if (mem_rdy) begin
            mem_rdy <= 1'b0;
            wcnt    <= 0;
        end else if (mem_rd || mem_wr) begin
            if (wcnt >= int'(mem_addr % 3)) begin
                mem_rdy <= 1'b1;
                if (mem_wr) mem[mem_addr] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr];
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    typedef struct {
        bit          wr;
        logic [7:0]  addr;
        logic [15:0] data;
        bit          probe;
        logic [7:0]  pc;
        logic [15:0] acc;
        logic [4:0]  psw;
        string       req;
    } item_t;

    item_t sbq[$];
    item_t it;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_rd(input logic [7:0] a, input string req);
        item_t x;
        x.wr = 1'b0; x.addr = a; x.data = '0; x.probe = 1'b0;
        x.pc = '0; x.acc = '0; x.psw = '0; x.req = req;
        sbq.push_back(x);
    endtask

    task automatic push_rdp(input logic [7:0] a, input logic [7:0] pc,
                            input logic [15:0] acc, input logic [4:0] psw, input string req);
        item_t x;
        x.wr = 1'b0; x.addr = a; x.data = '0; x.probe = 1'b1;
        x.pc = pc; x.acc = acc; x.psw = psw; x.req = req;
        sbq.push_back(x);
    endtask

    task automatic push_wr(input logic [7:0] a, input logic [15:0] d, input string req);
        item_t x;
        x.wr = 1'b1; x.addr = a; x.data = d; x.probe = 1'b0;
        x.pc = '0; x.acc = '0; x.psw = '0; x.req = req;
        sbq.push_back(x);
    endtask

    // monitor: every completed access is popped and compared
    always @(negedge clk) begin
        if (rst_n && mem_rdy && (mem_rd || mem_wr)) begin
            check(!(mem_rd && mem_wr), "R7", "both strobes", {mem_rd, mem_wr}, 0);
            if (sbq.size() == 0) begin
                check(1'b0, "R7", "unexpected access at", mem_addr, 0);
            end else begin
                it = sbq.pop_front();
                check(mem_wr == it.wr, it.req, "access kind", mem_wr, it.wr);
                check(mem_addr == it.addr, it.req, "address", mem_addr, it.addr);
                if (it.wr) check(mem_wdata == it.data, it.req, "write data", mem_wdata, it.data);
                if (it.probe) begin
                    check(pc_o == it.pc, it.req, "pc", pc_o, it.pc);
                    check(acc_o == it.acc, it.req, "acc", acc_o, it.acc);
                    check(psw_o == it.psw, it.req, "psw", psw_o, it.psw);
                end
            end
        end
    end

    task automatic wait_empty();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_ie();
        ie_set = 1'b1;
        @(negedge clk);
        ie_set = 1'b0;
        check(psw_o[4] == 1'b1, "R10", "enable bit after set", psw_o[4], 1);
    endtask

    initial begin
        rst_n  = 1'b0;
        irq    = 1'b1;
        ie_set = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pc_o == 8'h00, "R1", "pc in reset", pc_o, 0);
        check(acc_o == 16'h0, "R1", "acc in reset", acc_o, 0);
        check(psw_o == 5'h00, "R1", "psw in reset", psw_o, 0);
        check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);

        push_rdp(8'h00, 8'h01, 16'h0000, 5'h00, "R2");
        push_rd (8'h40, "R5");
        push_rd (8'h01, "R2");
        push_rd (8'h41, "R6");
        push_rdp(8'h02, 8'h03, 16'h8000, 5'h0C, "R6");
        push_wr (8'h50, 16'h8000, "R5");
        push_rd (8'h03, "R3");
        push_rd (8'h42, "R4");
        push_rd (8'h43, "R4");
        push_rdp(8'h04, 8'h05, 16'h0000, 5'h0B, "R6");
        push_rd (8'h44, "R4");
        push_rd (8'h45, "R4");
        push_rdp(8'h05, 8'h06, 16'h1234, 5'h0B, "R5");
        push_rdp(8'h08, 8'h09, 16'h1234, 5'h0B, "R5");
        push_rd (8'h46, "R4");
        push_wr (8'h51, 16'h1234, "R4");
        push_rd (8'h09, "R2");
        push_rd (8'h47, "R4");
        push_rdp(8'h0A, 8'h0B, 16'h1234, 5'h0B, "R4");
        // irq held high with enable clear: loop continues untouched
        for (int k = 0; k < 3; k++) push_rdp(8'h0A, 8'h0B, 16'h1234, 5'h0B, "R10");
        @(negedge clk);
        rst_n = 1'b1;
        wait_empty();

        // first entry: jump target saved below initial stack pointer
        push_wr (8'hEF, 16'h000A, "R8");
        push_rdp(8'hC0, 8'hC1, 16'h1234, 5'h0B, "R9");
        push_wr (8'h61, 16'h1234, "R9");
        push_rd (8'hC1, "R9");
        push_rd (8'hC1, "R9");
        push_rdp(8'hC1, 8'hC2, 16'h1234, 5'h0B, "R9");
        pulse_ie();
        wait_empty();

        // second entry: slot one word lower
        push_wr (8'hEE, 16'h00C1, "R8");
        push_rdp(8'hC0, 8'hC1, 16'h1234, 5'h0B, "R9");
        push_wr (8'h61, 16'h1234, "R9");
        push_rdp(8'hC1, 8'hC2, 16'h1234, 5'h0B, "R9");
        pulse_ie();
        wait_empty();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R7 watchdog: actual %0d pending expected 0", sbq.size());
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule